// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator processor. Each accepted operation takes an operation code, two operands (`opa` is normally the accumulator, `opb` the memory or register value), the current carry flag and the decimal-mode flag. It returns the new result together with fresh Negative, oVerflow, Zero and Carry values. A 4-bit write mask states which of those flags the operation is allowed to update. A separate strobe says whether the result should be written back at all.

The operations are: add and subtract with carry, in binary or packed BCD; compare; AND, OR and XOR; bit test; shift and rotate left and right; increment and decrement. The instruction sequencer keeps the register file and the status register. It applies `result` when `wr_result` is high, and it merges each flag whose mask bit is set. The block registers its outputs once, so a request sampled with `in_valid` at a rising edge is answered right after that edge.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low (asynchronous reset) and until the first accepted operation, `out_valid`, `result`, `wr_result`, `flag_we` and all four flag outputs read 0.
- R2: An operation sampled with `in_valid` high at a rising edge is presented right after that edge, with `out_valid` high for exactly that cycle. When `in_valid` is low at an edge, `out_valid` drops and `result`, `wr_result`, `flag_we` and the flags keep their values.
- R3: Op 4'h0 with `dec_mode`=0 adds: `result` = `opa`+`opb`+`carry_in` mod 256, C is the ninth sum bit, and V flags signed overflow. `wr_result`=1 and `flag_we`=4'b1111, where the mask bit order is bit3 N, bit2 V, bit1 Z, bit0 C.
- R4: Op 4'h1 with `dec_mode`=0 subtracts as `opa` + ~`opb` + `carry_in`. C is the inverted borrow and V flags signed overflow. `wr_result`=1 and `flag_we`=4'b1111.
- R5: Op 4'h2 compares `opa` with `opb` as `opa`-`opb` with an implied carry of 1. `carry_in` and `dec_mode` have no effect. N and Z come from the difference and C=1 when no borrow occurs. `wr_result`=0, `result` equals `opa`, and `flag_we`=4'b1011.
- R6: Ops 4'h3, 4'h4 and 4'h5 return `opa` AND, OR and XOR `opb` respectively, with `wr_result`=1 and `flag_we`=4'b1010.
- R7: Op 4'h6 (bit test) gives N = `opb` bit 7, V = `opb` bit 6 and Z = ((`opa` AND `opb`) == 0). `result` equals `opa`, `wr_result`=0 and `flag_we`=4'b1110.
- R8: Op 4'h7 shifts `opa` left and op 4'h8 shifts it right. A 0 enters the vacated bit and the bit pushed out goes to C, so `carry_in` and `opb` do not affect the result. `wr_result`=1 and `flag_we`=4'b1011.
- R9: Op 4'h9 rotates `opa` left and op 4'hA rotates it right. `carry_in` enters the vacated bit and the bit pushed out goes to C. `wr_result`=1 and `flag_we`=4'b1011.
- R10: Op 4'hB increments and op 4'hC decrements `opa` modulo 256. `wr_result`=1 and `flag_we`=4'b1010, so C is never written.
- R11: Op 4'h0 with `dec_mode`=1 adds packed BCD digits. A digit sum above 9 is corrected by adding 6, and C is the decimal carry out of the high digit. N and Z follow the decimal result, and V is the binary signed overflow of the same operands.
- R12: Op 4'h1 with `dec_mode`=1 subtracts packed BCD digits. A digit that borrows is corrected by subtracting 6, and C=1 exactly when the high digit does not borrow. N and Z follow the decimal result, and V is the binary overflow.
- R13: Whenever N or Z is written by an op other than bit test, N is bit 7 and Z is the all-zero test of the result (of the difference, for compare). A flag output whose mask bit is 0 reads 0. Op codes 4'hD to 4'hF return `result`=`opa`, `wr_result`=0, `flag_we`=0 and all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| opa | input | 8 | Accumulator-side operand; source of shifts and inc/dec |
| opb | input | 8 | Memory/register operand |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal-mode flag |
| out_valid | output | 1 | Result of an accepted operation is presented |
| result | output | 8 | Operation result |
| wr_result | output | 1 | Result is to be written back |
| flag_we | output | 4 | Flag write mask {N,V,Z,C} |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |

## Verification
The digit-range assertion assumes that decimal operands are valid packed BCD: a result digit is only promised to stay at or below 9 when every incoming digit already does. The binary-sum assertion is therefore limited to `dec_mode`=0. The assertions also assume that `in_valid` and the operands are steady around each rising edge. To stay inside these assumptions, the stimulus changes inputs only on falling edges, holds `in_valid` low throughout reset, and feeds decimal operations only BCD digits in the range 0 to 9. That digit range includes the 99+01 and 00-01 wrap cases.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC = 4'h0,
        OP_SBC = 4'h1,
        OP_CMP = 4'h2,
        OP_AND = 4'h3,
        OP_OR  = 4'h4,
        OP_XOR = 4'h5,
        OP_BIT = 4'h6,
        OP_ASL = 4'h7,
        OP_LSR = 4'h8,
        OP_ROL = 4'h9,
        OP_ROR = 4'hA,
        OP_INC = 4'hB,
        OP_DEC = 4'hC
    } alu_op_e;

    // flag vector positions {N,V,Z,C}
    localparam int FLAG_N = 3;
    localparam int FLAG_V = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

    localparam logic [3:0] WE_ALL  = 4'b1111;
    localparam logic [3:0] WE_NZC  = 4'b1011;
    localparam logic [3:0] WE_NZ   = 4'b1010;
    localparam logic [3:0] WE_NVZ  = 4'b1110;
    localparam logic [3:0] WE_NONE = 4'b0000;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    function automatic logic bcd_digits_ok(input logic [63:0] v, input int ndig);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (i < ndig && v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    input  logic             decimal,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int NDIG = WIDTH / 4;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH-1:0] bx;
    logic [WIDTH-1:0] bin_sum;
    logic [NDIG:0]    chain;

    assign bx       = sub ? ~b : b;
    assign chain[0] = cin;

    // digit-serial chain: binary when decimal is low, BCD-corrected otherwise
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [4:0] raw_d;
        logic [3:0] nib_d;
        logic       co_d;
        always_comb begin
            raw_d = {1'b0, a[4*g +: 4]} + {1'b0, bx[4*g +: 4]} + {4'b0, chain[g]};
            nib_d = raw_d[3:0];
            co_d  = raw_d[4];
            if (decimal) begin
                if (sub) begin
                    if (!raw_d[4]) nib_d = raw_d[3:0] - 4'd6;
                end else if (raw_d > 5'd9) begin
                    nib_d = raw_d[3:0] + 4'd6;
                    co_d  = 1'b1;
                end
            end
        end
        assign sum[4*g +: 4] = nib_d;
        assign chain[g+1]    = co_d;
    end

    // signed overflow always judged on the binary sum
    assign bin_sum = a + bx + WIDTH'(cin);
    assign ovf     = (a[MSB] == bx[MSB]) && (bin_sum[MSB] != a[MSB]);
    assign cout    = chain[NDIG];

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    input  logic             left,
    input  logic             rotate,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    logic fill;

    assign fill = rotate & cin;

    always_comb begin
        if (left) begin
            res  = {a[WIDTH-2:0], fill};
            cout = a[WIDTH-1];
        end else begin
            res  = {fill, a[WIDTH-1:1]};
            cout = a[0];
        end
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (sel)
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    input  logic             dec_mode,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             wr_result,
    output logic [3:0]       flag_we,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c
);
    localparam int MSB  = WIDTH - 1;
    localparam int NDIG = WIDTH / 4;

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] result;
        logic             wr;
        logic [3:0]       we;
        logic [3:0]       flags;
    } state_t;

    state_t st_d, st_q;

    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    // arithmetic unit
    logic [WIDTH-1:0] as_sum_d;
    logic             as_cout_d, as_ovf_d, as_sub_d, as_cin_d, as_dec_d;

    assign as_sub_d = (op_e != OP_ADC);
    assign as_cin_d = (op_e == OP_CMP) ? 1'b1 : carry_in;
    assign as_dec_d = dec_mode && (op_e != OP_CMP);

    acc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a       (opa),
        .b       (opb),
        .cin     (as_cin_d),
        .sub     (as_sub_d),
        .decimal (as_dec_d),
        .sum     (as_sum_d),
        .cout    (as_cout_d),
        .ovf     (as_ovf_d)
    );

    // shifter
    logic [WIDTH-1:0] sh_res_d;
    logic             sh_cout_d, sh_left_d, sh_rot_d;

    assign sh_left_d = (op_e == OP_ASL) || (op_e == OP_ROL);
    assign sh_rot_d  = (op_e == OP_ROL) || (op_e == OP_ROR);

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a      (opa),
        .cin    (carry_in),
        .left   (sh_left_d),
        .rotate (sh_rot_d),
        .res    (sh_res_d),
        .cout   (sh_cout_d)
    );

    // bitwise unit
    logic [WIDTH-1:0] lg_res_d;
    logic_sel_e       lg_sel_d;

    always_comb begin
        case (op_e)
            OP_OR:   lg_sel_d = LG_OR;
            OP_XOR:  lg_sel_d = LG_XOR;
            default: lg_sel_d = LG_AND;
        endcase
    end

    acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opa),
        .b   (opb),
        .sel (lg_sel_d),
        .res (lg_res_d)
    );

    // next-state computation
    always_comb begin
        logic [WIDTH-1:0] nz_src;
        logic [3:0]       flg;
        st_d       = st_q;
        st_d.valid = in_valid;
        nz_src     = opa;
        flg        = 4'b0000;
        if (in_valid) begin
            st_d.result = opa;
            st_d.wr     = 1'b0;
            st_d.we     = WE_NONE;
            case (op_e)
                OP_ADC, OP_SBC: begin
                    st_d.result  = as_sum_d;
                    st_d.wr      = 1'b1;
                    st_d.we      = WE_ALL;
                    flg[FLAG_V]  = as_ovf_d;
                    flg[FLAG_C]  = as_cout_d;
                end
                OP_CMP: begin
                    st_d.we      = WE_NZC;
                    flg[FLAG_C]  = as_cout_d;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.result  = lg_res_d;
                    st_d.wr      = 1'b1;
                    st_d.we      = WE_NZ;
                end
                OP_BIT: begin
                    st_d.we      = WE_NVZ;
                    flg[FLAG_V]  = opb[MSB-1];
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    st_d.result  = sh_res_d;
                    st_d.wr      = 1'b1;
                    st_d.we      = WE_NZC;
                    flg[FLAG_C]  = sh_cout_d;
                end
                OP_INC: begin
                    st_d.result  = opa + WIDTH'(1);
                    st_d.wr      = 1'b1;
                    st_d.we      = WE_NZ;
                end
                OP_DEC: begin
                    st_d.result  = opa - WIDTH'(1);
                    st_d.wr      = 1'b1;
                    st_d.we      = WE_NZ;
                end
                default: begin
                    st_d.we      = WE_NONE;
                end
            endcase

            nz_src = (op_e == OP_CMP) ? as_sum_d : st_d.result;
            if (op_e == OP_BIT) begin
                flg[FLAG_N] = opb[MSB];
                flg[FLAG_Z] = ((opa & opb) == '0);
            end else begin
                flg[FLAG_N] = nz_src[MSB];
                flg[FLAG_Z] = (nz_src == '0);
            end
            st_d.flags = flg & st_d.we;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign wr_result = st_q.wr;
    assign flag_we   = st_q.we;
    assign flag_n    = st_q.flags[FLAG_N];
    assign flag_v    = st_q.flags[FLAG_V];
    assign flag_z    = st_q.flags[FLAG_Z];
    assign flag_c    = st_q.flags[FLAG_C];

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_we)));

    // R3
    bin_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADC && !dec_mode) |=>
        ({flag_c, result} == $past({1'b0, opa} + {1'b0, opb} + (WIDTH+1)'(carry_in))));

    // R5
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> (!wr_result && result == $past(opa)));

    // R11
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_mode && (op == OP_ADC || op == OP_SBC) &&
         bcd_digits_ok(64'(opa), NDIG) && bcd_digits_ok(64'(opb), NDIG)) |=>
        bcd_digits_ok(64'(result), NDIG));

    // R13
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wr_result && flag_we[FLAG_Z]) |-> (flag_z == (result == '0)));

    // R13
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wr_result && flag_we[FLAG_N]) |-> (flag_n == result[MSB]));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'h0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic       carry_in = 1'b0;
    logic       dec_mode = 1'b0;
    logic       out_valid, wr_result, flag_n, flag_v, flag_z, flag_c;
    logic [7:0] result;
    logic [3:0] flag_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    acc_alu #(.WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
        .carry_in(carry_in), .dec_mode(dec_mode), .out_valid(out_valid), .result(result),
        .wr_result(wr_result), .flag_we(flag_we), .flag_n(flag_n), .flag_v(flag_v),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    // driver: apply one operation and queue its expected outcome
    // expected packing {wr, mask[3:0], flags N V Z C, result}
    task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic d, input logic [7:0] er,
                         input logic ewr, input logic [3:0] ewe, input logic [3:0] efl,
                         input string tag);
        @(negedge clk);
        op = o; opa = a; opb = b; carry_in = c; dec_mode = d; in_valid = 1'b1;
        exp_q.push_back({ewr, ewe, efl, er});
        tag_q.push_back(tag);
    endtask

    // monitor: compare presented results against the queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [16:0] got, want;
            string       t;
            got = {wr_result, flag_we, flag_n, flag_v, flag_z, flag_c, result};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected output: actual %h expected none", got);
            end else begin
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, got, want);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, result, wr_result, flag_we, flag_n, flag_v, flag_z, flag_c} !== 18'h0) begin
            errors++;
            $display("FAIL R1 reset state: actual %h expected 0",
                     {out_valid, result, wr_result, flag_we, flag_n, flag_v, flag_z, flag_c});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 binary add
        drive(4'h0, 8'h55, 8'h2D, 0, 0, 8'h82, 1, 4'hF, 4'b1100, "R3 85+45");
        drive(4'h0, 8'hFF, 8'h01, 0, 0, 8'h00, 1, 4'hF, 4'b0011, "R3 FF+01");
        drive(4'h0, 8'h10, 8'h20, 1, 0, 8'h31, 1, 4'hF, 4'b0000, "R3 carry in");
        // R4 binary subtract
        drive(4'h1, 8'h50, 8'h30, 1, 0, 8'h20, 1, 4'hF, 4'b0001, "R4 50-30");
        drive(4'h1, 8'h00, 8'h01, 1, 0, 8'hFF, 1, 4'hF, 4'b1000, "R4 borrow");
        drive(4'h1, 8'h80, 8'h01, 1, 0, 8'h7F, 1, 4'hF, 4'b0101, "R4 overflow");
        drive(4'h1, 8'h50, 8'h30, 0, 0, 8'h1F, 1, 4'hF, 4'b0001, "R4 carry clear");
        // R5 compare
        drive(4'h2, 8'h40, 8'h40, 0, 0, 8'h40, 0, 4'b1011, 4'b0011, "R5 equal");
        drive(4'h2, 8'h10, 8'h20, 1, 0, 8'h10, 0, 4'b1011, 4'b1000, "R5 less");
        drive(4'h2, 8'h40, 8'h40, 0, 1, 8'h40, 0, 4'b1011, 4'b0011, "R5 decimal ignored");
        // R6 logic
        drive(4'h3, 8'hF0, 8'h3C, 0, 0, 8'h30, 1, 4'b1010, 4'b0000, "R6 and");
        drive(4'h4, 8'h00, 8'h00, 1, 0, 8'h00, 1, 4'b1010, 4'b0010, "R6 or zero");
        drive(4'h5, 8'hAA, 8'hFF, 0, 0, 8'h55, 1, 4'b1010, 4'b0000, "R6 xor");
        drive(4'h5, 8'h0F, 8'hF0, 0, 0, 8'hFF, 1, 4'b1010, 4'b1000, "R6 xor neg");
        // R7 bit test
        drive(4'h6, 8'h0F, 8'hC0, 0, 0, 8'h0F, 0, 4'b1110, 4'b1110, "R7 high bits");
        drive(4'h6, 8'hFF, 8'h01, 1, 0, 8'hFF, 0, 4'b1110, 4'b0000, "R7 overlap");
        // R8 shifts
        drive(4'h7, 8'h81, 8'hFF, 0, 0, 8'h02, 1, 4'b1011, 4'b0001, "R8 asl out");
        drive(4'h7, 8'h40, 8'hFF, 1, 0, 8'h80, 1, 4'b1011, 4'b1000, "R8 asl no carry in");
        drive(4'h8, 8'h01, 8'h00, 1, 0, 8'h00, 1, 4'b1011, 4'b0011, "R8 lsr");
        // R9 rotates
        drive(4'h9, 8'h80, 8'h00, 1, 0, 8'h01, 1, 4'b1011, 4'b0001, "R9 rol");
        drive(4'hA, 8'h01, 8'h00, 1, 0, 8'h80, 1, 4'b1011, 4'b1001, "R9 ror carry");
        drive(4'hA, 8'h02, 8'h00, 0, 0, 8'h01, 1, 4'b1011, 4'b0000, "R9 ror plain");
        // R10 inc/dec
        drive(4'hB, 8'hFF, 8'h00, 1, 0, 8'h00, 1, 4'b1010, 4'b0010, "R10 inc wrap");
        drive(4'hC, 8'h00, 8'h00, 0, 0, 8'hFF, 1, 4'b1010, 4'b1000, "R10 dec wrap");
        drive(4'hB, 8'h7F, 8'h00, 0, 0, 8'h80, 1, 4'b1010, 4'b1000, "R10 inc sign");
        // R11 decimal add
        drive(4'h0, 8'h19, 8'h28, 0, 1, 8'h47, 1, 4'hF, 4'b0000, "R11 19+28");
        drive(4'h0, 8'h99, 8'h01, 0, 1, 8'h00, 1, 4'hF, 4'b0011, "R11 99+01");
        drive(4'h0, 8'h58, 8'h46, 1, 1, 8'h05, 1, 4'hF, 4'b0101, "R11 58+46+1");
        // R12 decimal subtract
        drive(4'h1, 8'h42, 8'h13, 1, 1, 8'h29, 1, 4'hF, 4'b0001, "R12 42-13");
        drive(4'h1, 8'h00, 8'h01, 1, 1, 8'h99, 1, 4'hF, 4'b1000, "R12 00-01");
        // R13 undefined code
        drive(4'hF, 8'h5A, 8'h33, 1, 1, 8'h5A, 0, 4'b0000, 4'b0000, "R13 undefined op");

        // R2 idle: outputs hold while inputs wander
        @(negedge clk);
        in_valid = 1'b0; op = 4'h0; opa = 8'h01; opb = 8'h01;
        @(negedge clk);
        opa = 8'hFF;
        @(negedge clk);
        checks++;
        if ({out_valid, result, wr_result, flag_we} !== {1'b0, 8'h5A, 1'b0, 4'h0}) begin
            errors++;
            $display("FAIL R2 idle hold: actual %h expected %h",
                     {out_valid, result, wr_result, flag_we}, {1'b0, 8'h5A, 1'b0, 4'h0});
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing outputs: actual %0d pending expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule